// File: doc/BRIEF.md
# DAC code gain and offset trim

This block is a per-channel digital correction stage placed ahead of a 16-bit converter. The host writes a raw code and two correction words, a gain word and an offset word, into one of several register banks. A range-select input names the active bank. Whenever the active bank's contents or the selection change, the block recomputes the code for the converter. That code is the raw code scaled by (gain + 1) / 65536, plus the offset word minus 32768, clamped to the unsigned 16-bit span. The new code is announced with a one-cycle strobe.

Each bank resets to a transparent setting: the gain word is all ones, so the scale factor is exactly one, and the offset word is the mid-scale value, so the offset term is zero. A channel used for one voltage range is built with a single bank. A channel that switches among several current ranges is built with one bank per range, and with seven banks by default. A small state machine sequences the arithmetic over two stages. In `ST_IDLE` it waits for a trigger. `ST_SCALE` registers the truncated product. `ST_EMIT` adds the offset, clamps the result and raises the strobe. A trigger seen in any state moves the machine to `ST_SCALE`. With no trigger, `ST_SCALE` goes to `ST_EMIT`, and `ST_EMIT` returns to `ST_IDLE`.

Top module: `dac_code_trim`

## Requirements
- R1: After reset, code_out is 0 and code_vld and code_clip are 0. Every bank holds input code 0, gain 16'hFFFF and offset 16'h8000.
- R2: The delivered code is floor(x1 * (m + 1) / 65536) + c - 32768, where x1, m and c are the active bank's input, gain and offset words. The product is formed at full 33-bit width and truncated by the shift.
- R3: A result below 0 is delivered as 0, and a result above 65535 is delivered as 65535. In both cases code_clip is 1 with that code; otherwise code_clip is 0.
- R4: The design has NUM_BANKS banks, and range_sel picks bank range_sel as the active one. A range_sel value of NUM_BANKS or above is ignored, and the previous bank stays active.
- R5: A write takes place on a clock edge with wr_en high. It loads wr_data into the bank numbered wr_bank. The register is chosen by wr_kind: 0 is the input code, 1 the gain word and 2 the offset word. wr_kind 3 is reserved, changes nothing and produces no strobe.
- R6: A write to the active bank triggers a recomputation. The clock edge that takes the write is followed two edges later by the edge that raises code_vld, and code_vld is high for exactly one cycle.
- R7: A change of range_sel to a different valid bank triggers a recomputation that uses the newly selected bank, with the same two-edge latency as R6.
- R8: A write to a bank that is not active updates that bank only. It raises no strobe and leaves code_out unchanged.
- R9: code_out and code_clip change only together with a code_vld pulse.
- R10: With a bank's gain and offset words at their reset values, the delivered code equals the input code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | BANK_W | Bank addressed by the write |
| wr_kind | input | 2 | Register type: 0 input code, 1 gain, 2 offset, 3 reserved |
| wr_data | input | DATA_W | Write data |
| range_sel | input | BANK_W | Active bank select |
| code_out | output | DATA_W | Corrected converter code |
| code_vld | output | 1 | One-cycle strobe marking a new code_out |
| code_clip | output | 1 | The last result was clamped at 0 or at full scale |

## Verification
The bench builds the block with its default parameters: 16-bit words and seven banks. With these values the full-scale and mid-scale codes can be driven directly, so both clamp rails, the exact unity gain and the zero gain (scale factor 1/65536) are all reachable. Seven banks also leave room for an out-of-range select value inside the 3-bit select field, for a write to a bank that is not active, and for the highest-numbered bank.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;

    typedef enum logic [1:0] {
        KIND_INPUT  = 2'd0,
        KIND_GAIN   = 2'd1,
        KIND_OFFSET = 2'd2,
        KIND_RSVD   = 2'd3
    } trim_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCALE = 2'd1,
        ST_EMIT  = 2'd2
    } trim_state_e;

endpackage

// File: rtl/dac_trim_bank.sv
module dac_trim_bank #(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [1:0]        wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [DATA_W-1:0] x1_o,
    output logic [DATA_W-1:0] gain_o,
    output logic [DATA_W-1:0] off_o
);
    import dac_trim_pkg::*;

    localparam logic [DATA_W-1:0] GAIN_RST = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] OFF_RST  = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] x1_q   [NUM_BANKS];
    logic [DATA_W-1:0] gain_q [NUM_BANKS];
    logic [DATA_W-1:0] off_q  [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (wr_bank == BANK_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                x1_q[b]   <= '0;
                gain_q[b] <= GAIN_RST;
                off_q[b]  <= OFF_RST;
            end else if (hit) begin
                unique case (trim_kind_e'(wr_kind))
                    KIND_INPUT:  x1_q[b]   <= wr_data;
                    KIND_GAIN:   gain_q[b] <= wr_data;
                    KIND_OFFSET: off_q[b]  <= wr_data;
                    KIND_RSVD:   ;
                endcase
            end
        end
    end

    assign x1_o   = x1_q[rd_bank];
    assign gain_o = gain_q[rd_bank];
    assign off_o  = off_q[rd_bank];

endmodule

// File: rtl/dac_trim_datapath.sv
module dac_trim_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_scale,
    input  logic              load_emit,
    input  logic [DATA_W-1:0] x1_i,
    input  logic [DATA_W-1:0] gain_i,
    input  logic [DATA_W-1:0] off_i,
    output logic [DATA_W-1:0] code_o,
    output logic              vld_o,
    output logic              clip_o
);
    localparam int GAIN_W = DATA_W + 1;
    localparam int PROD_W = DATA_W + GAIN_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(1) << (DATA_W - 1);
    localparam logic signed [SUM_W-1:0] TOPV  = (SUM_W'(1) << DATA_W) - SUM_W'(1);

    logic [GAIN_W-1:0] gain_eff;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] prod_shr;
    logic [PROD_W-1:0] scaled_q;
    logic [DATA_W-1:0] off_q;

    assign gain_eff = {1'b0, gain_i} + GAIN_W'(1);
    assign prod     = PROD_W'(x1_i) * PROD_W'(gain_eff);
    assign prod_shr = prod >> DATA_W;

    // stage one: truncated product and captured offset word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scaled_q <= '0;
            off_q    <= '0;
        end else if (load_scale) begin
            scaled_q <= prod_shr;
            off_q    <= off_i;
        end
    end

    logic signed [SUM_W-1:0] sum;
    logic [DATA_W-1:0]       code_d;
    logic                    clip_d;

    assign sum = $signed({2'b00, scaled_q}) + $signed(SUM_W'(off_q)) - HALF;

    always_comb begin
        if (sum < 0) begin
            code_d = '0;
            clip_d = 1'b1;
        end else if (sum > TOPV) begin
            code_d = {DATA_W{1'b1}};
            clip_d = 1'b1;
        end else begin
            code_d = sum[DATA_W-1:0];
            clip_d = 1'b0;
        end
    end

    // stage two: offset, clamp and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            clip_o <= 1'b0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= load_emit;
            if (load_emit) begin
                code_o <= code_d;
                clip_o <= clip_d;
            end
        end
    end

endmodule

// File: rtl/dac_code_trim.sv
module dac_code_trim #(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [1:0]        wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] range_sel,
    output logic [DATA_W-1:0] code_out,
    output logic              code_vld,
    output logic              code_clip
);
    import dac_trim_pkg::*;

    trim_state_e       state_q, state_d;
    logic [BANK_W-1:0] range_q;
    logic              sel_ok, range_chg, hit_active, trigger;
    logic              load_scale, load_emit;
    logic [DATA_W-1:0] x1_w, gain_w, off_w;

    assign sel_ok     = (int'(range_sel) < NUM_BANKS);
    assign range_chg  = sel_ok && (range_sel != range_q);
    assign hit_active = wr_en && (wr_kind != KIND_RSVD) && (wr_bank == range_q);
    assign trigger    = range_chg || hit_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            range_q <= '0;
        end else if (range_chg) begin
            range_q <= range_sel;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = trigger ? ST_SCALE : ST_IDLE;
            ST_SCALE: state_d = trigger ? ST_SCALE : ST_EMIT;
            ST_EMIT:  state_d = trigger ? ST_SCALE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        load_scale = 1'b0;
        load_emit  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SCALE: load_scale = 1'b1;
            ST_EMIT:  load_emit  = 1'b1;
            default:  ;
        endcase
    end

    dac_trim_bank #(
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_kind (wr_kind),
        .wr_data (wr_data),
        .rd_bank (range_q),
        .x1_o    (x1_w),
        .gain_o  (gain_w),
        .off_o   (off_w)
    );

    dac_trim_datapath #(
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_scale (load_scale),
        .load_emit  (load_emit),
        .x1_i       (x1_w),
        .gain_i     (gain_w),
        .off_i      (off_w),
        .code_o     (code_out),
        .vld_o      (code_vld),
        .clip_o     (code_clip)
    );

endmodule

// File: rtl/dac_code_trim_chk.sv
module dac_code_trim_chk #(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 7,
    parameter int BANK_W    = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [BANK_W-1:0]          wr_bank,
    input logic [1:0]                 wr_kind,
    input logic [BANK_W-1:0]          range_sel,
    input logic [BANK_W-1:0]          range_q,
    input dac_trim_pkg::trim_state_e  fsm_state,
    input logic [DATA_W-1:0]          code_out,
    input logic                       code_vld,
    input logic                       code_clip
);
    import dac_trim_pkg::*;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> !code_vld); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld |-> ($stable(code_out) && $stable(code_clip))); // R9

    AST_CLIP_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        code_clip |-> (code_out == '0 || code_out == {DATA_W{1'b1}})); // R3

    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind != 2'd3 && wr_bank == range_q && range_sel == range_q)
        ##1 (!wr_en && range_sel == range_q) |=> ##1 code_vld); // R6

    AST_RANGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && int'(range_sel) < NUM_BANKS && range_sel != range_q)
        ##1 (!wr_en && range_sel == range_q) |=> ##1 code_vld); // R7

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && wr_en && wr_bank != range_q && range_sel == range_q)
        |=> !code_vld); // R8

endmodule

bind dac_code_trim dac_code_trim_chk #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_kind   (wr_kind),
    .range_sel (range_sel),
    .range_q   (range_q),
    .fsm_state (state_q),
    .code_out  (code_out),
    .code_vld  (code_vld),
    .code_clip (code_clip)
);

// File: tb/dac_code_trim_test.sv
module dac_code_trim_test;
    localparam int DATA_W = 16;
    localparam int NB     = 7;
    localparam int BW     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [BW-1:0]     wr_bank = '0;
    logic [1:0]        wr_kind = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [BW-1:0]     range_sel = '0;
    logic [DATA_W-1:0] code_out;
    logic              code_vld;
    logic              code_clip;

    always #5 clk = ~clk;

    dac_code_trim #(.DATA_W(DATA_W), .NUM_BANKS(NB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_kind   (wr_kind),
        .wr_data   (wr_data),
        .range_sel (range_sel),
        .code_out  (code_out),
        .code_vld  (code_vld),
        .code_clip (code_clip)
    );

    typedef struct {
        int    code;
        bit    clip;
        int    cyc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   m_x1 [NB];
    int   m_g  [NB];
    int   m_c  [NB];
    int   active = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(int b, int at, string tag);
        exp_t   e;
        longint p;
        longint s;
        p = longint'(m_x1[b]) * longint'(m_g[b] + 1);
        s = (p >> 16) + longint'(m_c[b]) - 32768;
        e.clip = (s < 0) || (s > 65535);
        e.code = (s < 0) ? 0 : ((s > 65535) ? 65535 : int'(s));
        e.cyc  = at;
        e.tag  = tag;
        return e;
    endfunction

    // monitor: pops expected items as strobes appear
    always @(negedge clk) begin
        if (rst_n && code_vld) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected strobe, code %0d, expected none", code_out);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (int'(code_out) != e.code || code_clip != e.clip || cyc != e.cyc) begin
                    errors++;
                    $display("FAIL %s: code %0d clip %0d cycle %0d, expected code %0d clip %0d cycle %0d",
                             e.tag, code_out, code_clip, cyc, e.code, e.clip, e.cyc);
                end
            end
        end
    end

    task automatic do_write(int b, int kind, int data, string tag);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_bank = BW'(b);
        wr_kind = 2'(kind);
        wr_data = DATA_W'(data);
        if (kind != 3 && b < NB) begin
            if (kind == 0) m_x1[b] = data;
            if (kind == 1) m_g[b]  = data;
            if (kind == 2) m_c[b]  = data;
            if (b == active) q.push_back(model(b, cyc + 3, tag));
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_range(int r, string tag);
        @(negedge clk);
        range_sel = BW'(r);
        if (r < NB && r != active) begin
            active = r;
            q.push_back(model(r, cyc + 3, tag));
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_x1[b] = 0;
            m_g[b]  = 65535;
            m_c[b]  = 32768;
        end
        repeat (3) @(negedge clk);
        check_val("R1 code_out at reset", int'(code_out), 0);
        check_val("R1 code_vld at reset", int'(code_vld), 0);
        check_val("R1 code_clip at reset", int'(code_clip), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        do_write(0, 0, 1234, "R10 transparent mid code");
        do_write(0, 0, 65535, "R10 transparent full scale");
        do_write(0, 1, 0, "R2 gain zero truncates");
        do_write(0, 1, 16'h7FFF, "R2 half gain");
        do_write(0, 2, 0, "R3 underflow clamps to 0");
        do_write(0, 2, 16'hFFFF, "R2 positive offset in range");
        do_write(0, 1, 16'hFFFF, "R3 overflow clamps to full scale");

        do_write(3, 0, 500, "R8 inactive input write");
        do_write(3, 2, 16'h8064, "R8 inactive offset write");
        check_val("R8 output held after inactive writes", int'(code_out), 65535);

        do_write(0, 3, 0, "R5 reserved kind");
        check_val("R5 reserved write leaves output", int'(code_out), 65535);

        set_range(3, "R7 switch to bank 3");
        set_range(7, "R4 out-of-range select");
        check_val("R4 out-of-range select keeps output", int'(code_out), 600);
        set_range(6, "R4 last bank defaults");
        do_write(6, 0, 40000, "R6 write active last bank");
        do_write(6, 1, 16'hBFFF, "R2 three-quarter gain");
        set_range(0, "R7 back to bank 0 keeps trim");

        repeat (5) @(negedge clk);
        check_val("R6 all expected strobes seen", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6: watchdog expired, got hang, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule